// File: doc/BRIEF.md
# Clocked Start/Acknowledge Bus Slave with Byte-Lane Steering

This block is a single-beat slave on a synchronous 32-bit bus. It holds a small bank of word-wide registers. The bus is big-endian, and data lanes are picked from the full byte address and a two-bit size code; there are no byte-enable lines. The master opens a transfer with a start strobe that is active low for one clock. In that same clock it presents the address, the direction, the size and a burst request. It holds address and direction until the slave returns an active-low acknowledge.

After the start cycle, the slave waits a fixed number of clocks, set by a parameter, and then acknowledges. On a read it drives the addressed word on all four lanes. On a write it captures only the addressed lanes, sampling the write data on the acknowledge edge. A request that breaks natural alignment is still acknowledged, so the bus cannot hang. Such a request changes nothing, returns zero and pulses an error flag. A burst request is served as one beat, and the acknowledge carries a burst-inhibit indication.

Top module: `ts_ta_slave`

## Requirements
- R1: After reset, `ta_n` and `bi_n` are high, `err` is low, `rdata` is zero and every register reads as zero.
- R2: If `ts_n` is low at a clock edge while the slave is idle, `ta_n` is low for exactly one cycle. That cycle is the (WAIT_STATES+1)-th cycle after the start cycle, and `ta_n` stays high in every cycle between.
- R3: A low `ts_n` while a transfer is in progress, including its acknowledge cycle, is ignored. A new start is accepted in the cycle right after the acknowledge.
- R4: An aligned read returns the whole addressed register on `rdata[31:0]` in the acknowledge cycle. `rdata` is zero in every other cycle.
- R5: The size code `tsize` is 2'b00 for word, 2'b01 for byte and 2'b10 for halfword. The code 2'b11 is reserved and is handled as a misaligned request.
- R6: A byte write at offset `addr[1:0]`=o updates only bits [31-8o -: 8] of the register, taking them from the same bits of `wdata`. Offset 0 is the most significant lane.
- R7: A halfword write at offset 0 updates bits [31:16], and one at offset 2 updates bits [15:0]. Both take their data from the matching `wdata` lanes.
- R8: A request is misaligned when it is a halfword with `addr[0]`=1, a word with `addr[1:0]`≠0, or uses the reserved size. It is acknowledged at the normal time, leaves every register unchanged, returns zero data and raises `err` only in its acknowledge cycle.
- R9: Write data is sampled on the acknowledge edge. The value on `wdata` during the start cycle has no effect.
- R10: A transfer started with `burst_n` low is performed as a single beat, with `bi_n` low in its acknowledge cycle only.
- R11: The register is selected by `addr[IDX_W+1:2]`, where IDX_W = log2(REG_CNT). Higher address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all signals sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_n | input | 1 | Transfer start strobe, active low for one cycle |
| rd_wr_n | input | 1 | Direction: 1 read, 0 write |
| tsize | input | 2 | Size code: 00 word, 01 byte, 10 halfword |
| burst_n | input | 1 | Burst request, active low |
| addr | input | 32 | Full byte address |
| wdata | input | 32 | Write data, big-endian lanes |
| rdata | output | 32 | Read data, valid in the acknowledge cycle |
| ta_n | output | 1 | Transfer acknowledge, active low |
| bi_n | output | 1 | Burst inhibit, active low with acknowledge |
| err | output | 1 | Misaligned-request flag for one cycle |

## Verification
Word writes with distinct patterns, one to each register, show that register selection is correct. Reads from aliased high addresses show that the upper address bits are ignored. Byte writes at all four offsets, and halfword writes at both legal offsets, each followed by a full-word read, show whether the lane mapping is big-endian or mirrored. They also show whether neighbouring lanes are left intact. Misaligned halfwords, misaligned words and the reserved size code separate the error path from the normal path, both at the acknowledge and in the register contents. A changed write value between start and acknowledge, plus a stray start during a wait, tell acknowledge-edge capture and start filtering apart from capture at the start edge.

// File: rtl/ts_ta_slave.sv
module ts_ta_slave #(
  parameter int REG_CNT     = 8,
  parameter int WAIT_STATES = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ts_n,
  input  logic        rd_wr_n,
  input  logic [1:0]  tsize,
  input  logic        burst_n,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        ta_n,
  output logic        bi_n,
  output logic        err
);
  localparam int IDX_W = (REG_CNT > 1) ? $clog2(REG_CNT) : 1;
  localparam int CNT_W = (WAIT_STATES > 0) ? $clog2(WAIT_STATES + 1) : 1;

  logic [31:0]      regs [REG_CNT];
  logic             busy, rd_q, burst_q;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       size_q, off_q;
  logic [IDX_W-1:0] idx_q;
  logic [3:0]       lane_en;
  logic [31:0]      wmask;
  logic             done, bad;

  assign done = busy && (cnt == '0);
  assign bad  = (size_q == 2'b11) ||
                (size_q == 2'b10 && off_q[0]) ||
                (size_q == 2'b00 && off_q != 2'b00);

  always_comb begin
    case (size_q)
      2'b01:   lane_en = 4'b1000 >> off_q;
      2'b10:   lane_en = 4'b1100 >> off_q;
      default: lane_en = 4'b1111;
    endcase
  end

  for (genvar l = 0; l < 4; l++) begin : g_lane
    assign wmask[8*l +: 8] = {8{lane_en[l]}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      rd_q    <= 1'b0;
      burst_q <= 1'b0;
      size_q  <= 2'b00;
      off_q   <= 2'b00;
      idx_q   <= '0;
    end else if (!busy) begin
      if (!ts_n) begin
        busy    <= 1'b1;
        cnt     <= CNT_W'(WAIT_STATES);
        rd_q    <= rd_wr_n;
        burst_q <= !burst_n;
        size_q  <= tsize;
        off_q   <= addr[1:0];
        idx_q   <= addr[IDX_W+1:2];
      end
    end else if (done) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_CNT; i++) regs[i] <= '0;
    end else if (done && !rd_q && !bad) begin
      regs[idx_q] <= (regs[idx_q] & ~wmask) | (wdata & wmask);
    end
  end

  assign ta_n  = !done;
  assign err   = done && bad;
  assign bi_n  = !(done && burst_q);
  assign rdata = (done && rd_q && !bad) ? regs[idx_q] : 32'h0;

  assert_ta_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ta_n |=> ta_n);
  assert_ta_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ta_n) |-> $past(busy));
  assert_start_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ts_n) |=> ($stable(idx_q) && $stable(rd_q) && $stable(size_q)));
  assert_err_on_ta_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!ta_n && rdata == 32'h0));
  assert_bi_on_ta_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bi_n |-> !ta_n);
  assert_rdata_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ta_n && $past(ta_n)) |-> rdata == 32'h0);
endmodule

// File: tb/sim_ts_ta_slave.sv
module sim_ts_ta_slave;
  localparam int W = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ts_n = 1'b1, rd_wr_n = 1'b1, burst_n = 1'b1;
  logic [1:0]  tsize = 2'b00;
  logic [31:0] addr = '0, wdata = '0;
  logic [31:0] rdata;
  logic        ta_n, bi_n, err;

  int checks = 0, fails = 0;
  logic [31:0] mdl [8];

  always #5 clk = ~clk;

  ts_ta_slave #(.REG_CNT(8), .WAIT_STATES(W)) u0 (
    .clk(clk), .rst_n(rst_n), .ts_n(ts_n), .rd_wr_n(rd_wr_n), .tsize(tsize),
    .burst_n(burst_n), .addr(addr), .wdata(wdata), .rdata(rdata),
    .ta_n(ta_n), .bi_n(bi_n), .err(err));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit rd, input logic [31:0] a, input logic [1:0] sz,
                      input bit bst, input logic [31:0] wd, input string req,
                      input bit intrude);
    bit ok;
    logic [31:0] m, exp_rd;
    @(negedge clk);
    ts_n = 1'b0; rd_wr_n = rd; addr = a; tsize = sz; burst_n = !bst;
    wdata = rd ? 32'h0 : ~wd;
    ok = (sz == 2'b01) || (sz == 2'b10 && !a[0]) || (sz == 2'b00 && a[1:0] == 2'b00);
    m  = (sz == 2'b01) ? (32'hFF00_0000 >> (8*a[1:0])) :
         (sz == 2'b10) ? (32'hFFFF_0000 >> (8*a[1:0])) : 32'hFFFF_FFFF;
    exp_rd = (rd && ok) ? mdl[a[4:2]] : 32'h0;
    for (int c = 1; c <= W + 1; c++) begin
      @(negedge clk);
      ts_n = 1'b1;
      if (!rd) wdata = wd;
      if (c < W + 1) begin
        chk(ta_n === 1'b1, {req, " R2 wait"}, {31'b0, ta_n}, 32'h1);
        chk(rdata === 32'h0, {req, " R4 idle"}, rdata, 32'h0);
      end else begin
        chk(ta_n === 1'b0, {req, " R2 ack"}, {31'b0, ta_n}, 32'h0);
        chk(rdata === exp_rd, {req, " R4 data"}, rdata, exp_rd);
        chk(err === !ok, {req, " R8 err"}, {31'b0, err}, {31'b0, !ok});
        chk(bi_n === !bst, {req, " R10 bi"}, {31'b0, bi_n}, {31'b0, !bst});
      end
      if (intrude && c == 1) begin
        ts_n = 1'b0; rd_wr_n = 1'b0; addr = 32'h1C; tsize = 2'b00;
      end
    end
    if (!rd && ok) mdl[a[4:2]] = (mdl[a[4:2]] & ~m) | (wd & m);
    @(negedge clk);
    ts_n = 1'b1;
    chk(ta_n === 1'b1 && err === 1'b0 && bi_n === 1'b1, {req, " R2 single ack"},
        {29'b0, ta_n, err, bi_n}, 32'h5);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = 32'h0;
    repeat (3) @(negedge clk);
    chk(ta_n === 1'b1 && bi_n === 1'b1 && err === 1'b0, "R1 reset outputs",
        {29'b0, ta_n, bi_n, err}, 32'h6);
    chk(rdata === 32'h0, "R1 reset rdata", rdata, 32'h0);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) xfer(1, 32'(i*4), 2'b00, 0, 0, "R1 regs zero", 0);
    for (int i = 0; i < 8; i++) xfer(0, 32'(i*4), 2'b00, 0, 32'h1111_1111 * (i+1) ^ 32'hA5C3_0F69, "R11 word write", 0);
    for (int i = 0; i < 8; i++) xfer(1, 32'hFFFF_FF00 | 32'(i*4), 2'b00, 0, 0, "R11 alias read", 0);
    for (int o = 0; o < 4; o++) begin
      xfer(0, 32'h08 + 32'(o), 2'b01, 0, 32'h0102_0304 << o, "R6 byte write", 0);
      xfer(1, 32'h08, 2'b00, 0, 0, "R6 byte readback", 0);
    end
    xfer(0, 32'h0C, 2'b10, 0, 32'hDEAD_BEEF, "R7 half off0", 0);
    xfer(1, 32'h0C, 2'b00, 0, 0, "R7 readback", 0);
    xfer(0, 32'h0E, 2'b10, 0, 32'hCAFE_F00D, "R7 half off2", 0);
    xfer(1, 32'h0C, 2'b00, 0, 0, "R7 readback", 0);
    xfer(0, 32'h11, 2'b10, 0, 32'hFFFF_FFFF, "R8 half misaligned", 0);
    xfer(0, 32'h12, 2'b00, 0, 32'hFFFF_FFFF, "R8 word misaligned", 0);
    xfer(0, 32'h10, 2'b11, 0, 32'hFFFF_FFFF, "R5 reserved size", 0);
    xfer(1, 32'h13, 2'b10, 0, 0, "R8 misaligned read", 0);
    xfer(1, 32'h10, 2'b00, 0, 0, "R8 unchanged", 0);
    xfer(0, 32'h14, 2'b00, 0, 32'h5A5A_1234, "R9 late wdata", 0);
    xfer(1, 32'h14, 2'b00, 0, 0, "R9 readback", 0);
    xfer(1, 32'h04, 2'b00, 1, 0, "R10 burst read", 0);
    xfer(0, 32'h18, 2'b00, 1, 32'h7777_0001, "R10 burst write", 0);
    xfer(1, 32'h00, 2'b00, 0, 0, "R3 stray start", 1);
    xfer(1, 32'h1C, 2'b00, 0, 0, "R3 stray ignored", 0);
    xfer(1, 32'h1A, 2'b01, 0, 0, "R5 byte read", 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule